// File: doc/BRIEF.md
# Periodic Scheduled Frame Generator

This block generates test frames on two independent transmit ports, each frame launched at a fixed point inside a repeating scheduling period. A downstream switch that opens its path for one port during a known window can therefore be set up before each frame arrives. The frame length, the launch offset and the sending interval are programmed per port. The period length is programmed once, because a single free-running period counter times both ports. This counter also drives a one-cycle period-start pulse that other blocks can lock to.

Each port drives a word stream with valid, start-of-frame and end-of-frame markers. Cycles without frame data carry a filler word. The payload is an incrementing byte pattern seeded with a per-port frame sequence number, so a receiver can check every byte. Configuration writes land in staging registers and take effect only at the next period boundary. A frame that would not fit before the end of the period is dropped and flagged.

Top module: `sched_frame_gen`

## Requirements
- R1: A period counter runs from 0 to P-1 and wraps, where P is the active period length (default 528). `pstart_o` is high for exactly the cycle in which the counter is 0.
- R2: A configuration write changes no output behaviour in the period in which it is made. It takes effect from the first period start after the write.
- R3: When a port sends, it raises valid for `len` consecutive cycles starting in the cycle where the counter equals its offset. `sof` is high on the first of these words and `eof` on the last. The defaults are offset 0 and length 254 for port 0, and offset 264 and length 254 for port 1.
- R4: The two ports are independent. Reconfiguring one port leaves the other port's stream unchanged.
- R5: The port flags an error when the counter reaches its offset while `len` is 0 or offset+len exceeds P. The flag is a one-cycle pulse on `cfg_err_o` in that cycle, and the port sends no word in that period. offset+len equal to P is allowed. An offset of P or more never matches, so it sends nothing and flags nothing.
- R6: Byte b of word i of a frame is (seq + 4*i + b) mod 256, with byte 0 in bits 7:0. seq is the port's sequence number. It is 0 after reset and increases by one after each frame that is sent; it does not change when a frame is flagged and dropped.
- R7: In a cycle where valid is low, the data is the filler word 32'h07070707 and `sof` and `eof` are low.
- R8: A port sends in the first period after reset. After that, with an interval N, it sends in every N-th period, counted from the last period in which it was eligible. An interval of 0 acts as 1.
- R9: The write addresses are: 0 for the period length, 4+4p for the offset of port p, 5+4p for its length and 6+4p for its interval. A period value below 2 is stored as 2. Writes to any other address have no effect.
- R10: While reset is low, every port shows valid, sof, eof and error low and drives the filler word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration write address |
| cfg_wdata | input | 16 | Configuration write data |
| pstart_o | output | 1 | Period-start pulse |
| tx_valid_o | output | 2 | Per-port word valid |
| tx_sof_o | output | 2 | Per-port start of frame |
| tx_eof_o | output | 2 | Per-port end of frame |
| tx_data_o | output | 64 | Per-port data word, port p in bits 32p+31:32p |
| cfg_err_o | output | 2 | Per-port pulse for a frame dropped because it does not fit |

## Verification
The hardest situations to reach are the ones at a period boundary: a staged configuration that must not take effect early, and a frame that ends exactly on the last cycle of the period. The bench keeps its own model of staged and active settings and applies the staged values only when it steps from one period to the next. It writes new settings in the middle of a running period and checks every cycle of that period and of the following ones. To cover the fit rule, the bench sets one port to a length that overruns the period by a single cycle, and to a length that fills the period exactly. It follows each with a period that shows whether the sequence number advanced.

// File: rtl/sfg_pkg.sv
// Package: shared address map and payload pattern helper for the
// periodic scheduled frame generator.
package sfg_pkg;
    localparam int unsigned ADDR_PERIOD = 0;
    localparam int unsigned PORT_BASE   = 4;
    localparam int unsigned PORT_STRIDE = 4;
    localparam int unsigned SLOT_OFFSET = 0;
    localparam int unsigned SLOT_LENGTH = 1;
    localparam int unsigned SLOT_IVL    = 2;
    localparam int unsigned MIN_PERIOD  = 2;

    // Byte value of the payload for a given seed, beat and byte lane.
    function automatic logic [7:0] pat_byte(input logic [7:0] seed,
                                            input logic [7:0] beat_lo,
                                            input int unsigned lanes,
                                            input int unsigned lane);
        logic [31:0] s;
        s = 32'(seed) + 32'(beat_lo) * 32'(lanes) + 32'(lane);
        return s[7:0];
    endfunction
endpackage

// File: rtl/sfg_cfg_regs.sv
// Configuration store: write-only staging registers and the active copy
// used by the datapath. Assumes wrap_i is high on the last cycle of a period;
// staged values are copied to the active set on that edge.
module sfg_cfg_regs #(
    parameter int unsigned NP      = 2,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned IVL_W   = 4,
    parameter int unsigned ADDR_W  = 4,
    parameter logic [CNT_W-1:0]    DEF_PER = 16'd528,
    parameter logic [NP*CNT_W-1:0] DEF_OFF = {16'd264, 16'd0},
    parameter logic [NP*CNT_W-1:0] DEF_LEN = {16'd254, 16'd254},
    parameter logic [NP*IVL_W-1:0] DEF_IVL = {4'd1, 4'd1}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [CNT_W-1:0]     cfg_wdata,
    input  logic                 wrap_i,
    output logic [CNT_W-1:0]     act_per_o,
    output logic [NP*CNT_W-1:0]  act_off_o,
    output logic [NP*CNT_W-1:0]  act_len_o,
    output logic [NP*IVL_W-1:0]  stg_ivl_o
);
    import sfg_pkg::*;

    logic [CNT_W-1:0] stg_per;
    logic             per_hit;
    logic [CNT_W-1:0] per_clamped;

    assign per_hit     = cfg_we && (cfg_addr == ADDR_W'(ADDR_PERIOD));
    assign per_clamped = (cfg_wdata < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : cfg_wdata;

    // Staging and activation of the shared period length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_per   <= DEF_PER;
            act_per_o <= DEF_PER;
        end else begin
            if (per_hit) stg_per <= per_clamped;
            if (wrap_i)  act_per_o <= stg_per;
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_port_cfg
        localparam int unsigned BASE = PORT_BASE + PORT_STRIDE * p;
        logic [CNT_W-1:0] stg_off, stg_len;
        logic [IVL_W-1:0] stg_ivl;
        logic off_hit, len_hit, ivl_hit;

        assign off_hit = cfg_we && (cfg_addr == ADDR_W'(BASE + SLOT_OFFSET));
        assign len_hit = cfg_we && (cfg_addr == ADDR_W'(BASE + SLOT_LENGTH));
        assign ivl_hit = cfg_we && (cfg_addr == ADDR_W'(BASE + SLOT_IVL));

        // Staging of per-port settings and activation at the period edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_off <= DEF_OFF[p*CNT_W +: CNT_W];
                stg_len <= DEF_LEN[p*CNT_W +: CNT_W];
                stg_ivl <= DEF_IVL[p*IVL_W +: IVL_W];
                act_off_o[p*CNT_W +: CNT_W] <= DEF_OFF[p*CNT_W +: CNT_W];
                act_len_o[p*CNT_W +: CNT_W] <= DEF_LEN[p*CNT_W +: CNT_W];
            end else begin
                if (off_hit) stg_off <= cfg_wdata;
                if (len_hit) stg_len <= cfg_wdata;
                if (ivl_hit) stg_ivl <= cfg_wdata[IVL_W-1:0];
                if (wrap_i) begin
                    act_off_o[p*CNT_W +: CNT_W] <= stg_off;
                    act_len_o[p*CNT_W +: CNT_W] <= stg_len;
                end
            end
        end

        assign stg_ivl_o[p*IVL_W +: IVL_W] = stg_ivl;

        AST_ACTIVE_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !wrap_i |=> $stable(act_len_o[p*CNT_W +: CNT_W])); // R2
    end

    AST_ACTIVE_PER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(act_per_o)); // R2
    AST_PER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        act_per_o >= CNT_W'(MIN_PERIOD)); // R9
endmodule

// File: rtl/sfg_period_timer.sv
// Free-running period counter. Counts 0..per_i-1, flags the last cycle
// (wrap) and the first cycle (period start). Assumes per_i >= 2 and that
// per_i only changes on the edge where wrap is high.
module sfg_period_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] per_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             pstart_o
);
    assign wrap_o   = (cnt_o == per_i - CNT_W'(1));
    assign pstart_o = (cnt_o == '0);

    // Advance the counter, returning to zero after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (wrap_o) cnt_o <= '0;
        else             cnt_o <= cnt_o + CNT_W'(1);
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o < per_i); // R1
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> pstart_o); // R1
    AST_PSTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pstart_o |=> !pstart_o); // R1
endmodule

// File: rtl/sfg_tx_port.sv
// One transmit port. Launches a frame when the period counter equals the
// active offset, provided the port is eligible this period and the frame
// fits before the period ends; otherwise pulses an error. Assumes the
// active settings are stable within a period.
module sfg_tx_port #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned IVL_W  = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEQ_W  = 8,
    parameter logic [DATA_W-1:0] FILL = 32'h07070707
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              wrap_i,
    input  logic [CNT_W-1:0]  per_i,
    input  logic [CNT_W-1:0]  off_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic [IVL_W-1:0]  stg_ivl_i,
    output logic              valid_o,
    output logic              sof_o,
    output logic              eof_o,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o
);
    import sfg_pkg::*;

    localparam int unsigned LANES = DATA_W / 8;

    logic             busy_q;
    logic [CNT_W-1:0] beat_q;
    logic [SEQ_W-1:0] seq_q;
    logic [IVL_W-1:0] ivl_q;
    logic             elig, hit, bad, start;
    logic [CNT_W-1:0] cur_beat;
    logic [CNT_W:0]   end_pos;

    assign elig     = (ivl_q == '0);
    assign hit      = rst_n && elig && !busy_q && (cnt_i == off_i);
    assign end_pos  = {1'b0, off_i} + {1'b0, len_i};
    assign bad      = (len_i == '0) || (end_pos > {1'b0, per_i});
    assign start    = hit && !bad;
    assign err_o    = hit && bad;
    assign cur_beat = start ? '0 : beat_q;
    assign valid_o  = start || busy_q;
    assign sof_o    = start;
    assign eof_o    = valid_o && (cur_beat == len_i - CNT_W'(1));

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign data_o[b*8 +: 8] = valid_o
            ? pat_byte(8'(seq_q), cur_beat[7:0], LANES, b)
            : FILL[b*8 +: 8];
    end

    // Track beats of the frame in flight and the per-frame sequence number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            beat_q <= '0;
            seq_q  <= '0;
        end else if (valid_o) begin
            if (eof_o) begin
                busy_q <= 1'b0;
                beat_q <= '0;
                seq_q  <= seq_q + SEQ_W'(1);
            end else begin
                busy_q <= 1'b1;
                beat_q <= cur_beat + CNT_W'(1);
            end
        end
    end

    // Count down the periods until this port is eligible again.
    always_ff @(posedge clk) begin
        if (!rst_n)      ivl_q <= '0;
        else if (wrap_i) ivl_q <= (ivl_q != '0)      ? ivl_q - IVL_W'(1)
                                : (stg_ivl_i == '0) ? '0
                                : stg_ivl_i - IVL_W'(1);
    end

    AST_NO_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && wrap_i) |-> eof_o); // R5
    AST_FRAME_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !eof_o) |=> (valid_o && !sof_o)); // R3
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> (seq_q == $past(seq_q) + SEQ_W'(1))); // R6
    AST_ERR_NO_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> $stable(seq_q)); // R5
endmodule

// File: rtl/sched_frame_gen.sv
// Top of the periodic scheduled frame generator: configuration store,
// shared period timer and one transmit port per generate iteration.
// Assumes a single clock domain and synchronous active-low reset.
module sched_frame_gen #(
    parameter int unsigned NP     = 2,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned IVL_W  = 4,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEQ_W  = 8,
    parameter logic [CNT_W-1:0]    DEF_PER = 16'd528,
    parameter logic [NP*CNT_W-1:0] DEF_OFF = {16'd264, 16'd0},
    parameter logic [NP*CNT_W-1:0] DEF_LEN = {16'd254, 16'd254},
    parameter logic [NP*IVL_W-1:0] DEF_IVL = {4'd1, 4'd1},
    parameter logic [DATA_W-1:0]   FILL    = 32'h07070707
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [CNT_W-1:0]     cfg_wdata,
    output logic                 pstart_o,
    output logic [NP-1:0]        tx_valid_o,
    output logic [NP-1:0]        tx_sof_o,
    output logic [NP-1:0]        tx_eof_o,
    output logic [NP*DATA_W-1:0] tx_data_o,
    output logic [NP-1:0]        cfg_err_o
);
    logic [CNT_W-1:0]    act_per, cnt;
    logic [NP*CNT_W-1:0] act_off, act_len;
    logic [NP*IVL_W-1:0] stg_ivl;
    logic                wrap;

    sfg_cfg_regs #(
        .NP(NP), .CNT_W(CNT_W), .IVL_W(IVL_W), .ADDR_W(ADDR_W),
        .DEF_PER(DEF_PER), .DEF_OFF(DEF_OFF), .DEF_LEN(DEF_LEN), .DEF_IVL(DEF_IVL)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .wrap_i(wrap), .act_per_o(act_per),
        .act_off_o(act_off), .act_len_o(act_len), .stg_ivl_o(stg_ivl)
    );

    sfg_period_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .per_i(act_per), .cnt_o(cnt),
        .wrap_o(wrap), .pstart_o(pstart_o)
    );

    for (genvar p = 0; p < NP; p++) begin : g_port
        sfg_tx_port #(
            .CNT_W(CNT_W), .IVL_W(IVL_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W), .FILL(FILL)
        ) port_i (
            .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .wrap_i(wrap), .per_i(act_per),
            .off_i(act_off[p*CNT_W +: CNT_W]), .len_i(act_len[p*CNT_W +: CNT_W]),
            .stg_ivl_i(stg_ivl[p*IVL_W +: IVL_W]),
            .valid_o(tx_valid_o[p]), .sof_o(tx_sof_o[p]), .eof_o(tx_eof_o[p]),
            .data_o(tx_data_o[p*DATA_W +: DATA_W]), .err_o(cfg_err_o[p])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (tx_valid_o == '0 && cfg_err_o == '0)); // R10
endmodule

// File: tb/sched_frame_gen_tb_top.sv
module sched_frame_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] FILLW = 32'h07070707;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        pstart_o;
    logic [1:0]  tx_valid_o, tx_sof_o, tx_eof_o, cfg_err_o;
    logic [63:0] tx_data_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // bench model: staged and active settings
    int sh_per, ac_per;
    int sh_off[2], sh_len[2], sh_ivl[2];
    int ac_off[2], ac_len[2];
    int ivlc[2], seqn[2];
    int wr_a[8], wr_d[8];
    int wr_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sched_frame_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pstart_o(pstart_o), .tx_valid_o(tx_valid_o),
        .tx_sof_o(tx_sof_o), .tx_eof_o(tx_eof_o), .tx_data_o(tx_data_o),
        .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic model_write(input int a, input int d);
        if (a == 0) sh_per = (d < 2) ? 2 : d;
        else if (a == 4 || a == 8)  sh_off[(a-4)/4] = d;
        else if (a == 5 || a == 9)  sh_len[(a-5)/4] = d;
        else if (a == 6 || a == 10) sh_ivl[(a-6)/4] = d & 15;
    endtask

    function automatic logic [31:0] exp_word(input int sq, input int beat);
        logic [31:0] w;
        for (int b = 0; b < 4; b++) w[b*8 +: 8] = 8'((sq + 4*beat + b) % 256);
        return w;
    endfunction

    // Check one whole period cycle by cycle; issue queued writes at its start.
    task automatic run_period(input string tag);
        for (int k = 0; k < ac_per; k++) begin
            if (k < wr_n) begin
                cfg_we = 1'b1; cfg_addr = 4'(wr_a[k]); cfg_wdata = 16'(wr_d[k]);
                model_write(wr_a[k], wr_d[k]);
            end else begin
                cfg_we = 1'b0;
            end
            chk(pstart_o == (k == 0), "R1", $sformatf("pstart k=%0d", k),
                64'(pstart_o), 64'(k == 0));
            for (int p = 0; p < 2; p++) begin
                bit elig, bad, ev, es, ee, er;
                logic [3:0] actc, expc;
                logic [31:0] ed;
                elig = (ivlc[p] == 0);
                bad  = (ac_len[p] == 0) || (ac_off[p] + ac_len[p] > ac_per);
                ev = elig && !bad && k >= ac_off[p] && k < ac_off[p] + ac_len[p];
                es = ev && k == ac_off[p];
                ee = ev && k == ac_off[p] + ac_len[p] - 1;
                er = elig && bad && k == ac_off[p];
                actc = {tx_valid_o[p], tx_sof_o[p], tx_eof_o[p], cfg_err_o[p]};
                expc = {ev, es, ee, er};
                if (er || cfg_err_o[p])
                    chk(actc == expc, "R5", $sformatf("ctl p%0d k=%0d", p, k), 64'(actc), 64'(expc));
                else
                    chk(actc == expc, tag, $sformatf("ctl p%0d k=%0d", p, k), 64'(actc), 64'(expc));
                ed = ev ? exp_word(seqn[p], k - ac_off[p]) : FILLW;
                chk(tx_data_o[p*32 +: 32] == ed, ev ? "R6" : "R7",
                    $sformatf("data p%0d k=%0d", p, k), 64'(tx_data_o[p*32 +: 32]), 64'(ed));
                if (ee) seqn[p]++;
            end
            @(negedge clk); #1;
        end
        cfg_we = 1'b0;
        wr_n = 0;
        ac_per = sh_per;
        for (int p = 0; p < 2; p++) begin
            ac_off[p] = sh_off[p];
            ac_len[p] = sh_len[p];
            if (ivlc[p] != 0) ivlc[p]--;
            else ivlc[p] = (sh_ivl[p] == 0) ? 0 : sh_ivl[p] - 1;
        end
    endtask

    task automatic queue_wr(input int a, input int d);
        wr_a[wr_n] = a; wr_d[wr_n] = d; wr_n++;
    endtask

    // R10: reset state, then release into period start
    task automatic t_reset();
        sh_per = 528; ac_per = 528;
        sh_off = '{0, 264}; ac_off = '{0, 264};
        sh_len = '{254, 254}; ac_len = '{254, 254};
        sh_ivl = '{1, 1}; ivlc = '{0, 0}; seqn = '{0, 0};
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(tx_valid_o == 2'b00 && cfg_err_o == 2'b00 && tx_sof_o == 2'b00 && tx_eof_o == 2'b00,
            "R10", "ctl in reset", 64'({tx_valid_o, cfg_err_o}), 64'(0));
        chk(tx_data_o == {FILLW, FILLW}, "R10", "data in reset", tx_data_o, {FILLW, FILLW});
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // R3 defaults, R6 seq 0
    task automatic t_default();
        run_period("R3");
    endtask

    // R2 staged writes, R9 map incl. ignored address, R4 independence
    task automatic t_reconfig();
        queue_wr(0, 40);
        queue_wr(4, 3);  queue_wr(5, 5);
        queue_wr(8, 20); queue_wr(9, 20);
        queue_wr(15, 1); queue_wr(3, 7); queue_wr(7, 2);
        run_period("R2");
        run_period("R9");
        queue_wr(5, 9);
        run_period("R4");
        run_period("R4");
    endtask

    // R8 interval on port 1 only, including interval 0
    task automatic t_interval();
        queue_wr(10, 3);
        run_period("R8");
        for (int i = 0; i < 6; i++) run_period("R8");
        queue_wr(10, 0);
        run_period("R8");
        for (int i = 0; i < 4; i++) run_period("R8");
    endtask

    // R5 fit rule: overrun by one, length zero, exact fit, offset past end
    task automatic t_fit();
        queue_wr(5, 38);
        run_period("R5");
        run_period("R5");
        queue_wr(5, 0);
        run_period("R5");
        run_period("R5");
        queue_wr(5, 37);
        run_period("R5");
        run_period("R5");
        queue_wr(4, 45);
        run_period("R5");
        run_period("R5");
        queue_wr(0, 1);
        queue_wr(8, 0); queue_wr(9, 2);
        run_period("R9");
        run_period("R9");
        run_period("R9");
    endtask

    initial begin
        #1;
        t_reset();
        t_default();
        t_reconfig();
        t_interval();
        t_fit();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule